// File: doc/BRIEF.md
# Full-duplex SPI master with hardware CRC append and check

This block is the data path of a full-duplex SPI master. Its clock idles low. It drives MOSI on the falling edge of SCK and samples MISO on the rising edge. Frames are 8 or 16 bits long and go out MSB first, at a fixed SCK rate set by a parameter. Each frame is taken through a valid/ready handshake and each received frame is returned as a one-cycle pulse. Configuration arrives through single-cycle write strobes: a polynomial write, a control write, and a write-one-to-clear for the error flag.

Two serial CRC accumulators run bit by bit, one over the transmitted data and one over the received data. Both use the programmed polynomial, and their width follows the frame size. When software flags a frame as the last one, the block appends the transmit accumulator as an extra frame once that data frame has been shifted. During that CRC frame both accumulators hold still. The frame received at the same time is compared with the receive accumulator, and it is not handed out as data. A mismatch sets a sticky error flag, and the interrupt output reflects that flag when interrupts are enabled.

Top module: `spi_crc_master`

## Requirements
- R1: After reset, sck is 0, tx_ready is 1, and rx_valid, crc_pend, crc_err and irq are all 0.
- R2: A data frame has 8 bits when the frame-size field ctrl_frame16 is 0 and 16 bits when it is 1. An 8-bit frame sends tx_data[7:0]. Bits go out MSB first on mosi. Each bit lasts 2*HALF_DIV clock cycles, with sck low in the first half. Mosi changes only while sck is low and miso is sampled as sck rises.
- R3: For each received data frame, rx_valid pulses high for exactly one cycle with the received bits in rx_data, first-received bit most significant. In 8-bit mode rx_data[15:8] is 0.
- R4: Each data bit, sent or received, updates its accumulator MSB first. The bit is XORed with the accumulator's top bit (bit 15, or bit 7 in 8-bit mode). The accumulator then shifts left by one, is XORed with the polynomial when that result is 1, and is truncated to the frame width. There is no reflection and no final XOR. Accumulators carry over from message to message until they are cleared.
- R5: Accepting a frame with tx_last=1 while CRC is enabled sets crc_pend. After that frame the block sends the transmit accumulator as one extra frame and clears crc_pend when that frame ends. With CRC disabled, tx_last has no effect and no extra frame is sent.
- R6: Neither accumulator changes while the CRC frame is being shifted.
- R7: A control write that changes the CRC enable from 0 to 1 clears both accumulators to zero.
- R8: The frame received during the CRC frame is compared with the receive accumulator. A mismatch sets crc_err, a match leaves it unchanged, and this frame never produces an rx_valid pulse.
- R9: irq is high exactly when crc_err is set and the error-interrupt enable ctrl_err_ie was written as 1.
- R10: crc_err stays set until a write with err_clr_we=1 and err_clr=1 clears it. A write with err_clr=0 leaves it set.
- R11: The frame-size field is ignored when the control write comes while tx_ready is 0 or in the cycle a frame is accepted. The enable fields are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_we | input | 1 | Polynomial write strobe |
| poly_wdata | input | FRAME_W | Polynomial value (low byte used in 8-bit mode) |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_crc_en | input | 1 | CRC enable field |
| ctrl_frame16 | input | 1 | Frame size field: 0 = 8 bits, 1 = 16 bits |
| ctrl_err_ie | input | 1 | Error interrupt enable field |
| err_clr_we | input | 1 | Error flag write strobe |
| err_clr | input | 1 | Write 1 to clear crc_err |
| tx_valid | input | 1 | Transmit frame offered |
| tx_data | input | FRAME_W | Transmit frame |
| tx_last | input | 1 | Next-is-CRC request for this frame |
| tx_ready | output | 1 | Block idle, frame accepted when tx_valid |
| rx_valid | output | 1 | One-cycle received data pulse |
| rx_data | output | FRAME_W | Received data frame |
| crc_pend | output | 1 | Next-is-CRC request outstanding |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| irq | output | 1 | Error interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every cycle, the assertions check several local rules. SCK stays low while the block is idle, and MOSI holds steady while SCK is high. Rx_valid is a single pulse. The sticky error flag only drops on a one-write, and the interrupt only rises with the flag. A flagged last frame raises crc_pend, and the end of a CRC frame never emits rx_valid. The frame size is frozen during transfers. Only the bench scenarios can show the arithmetic: the CRC value on the wire and the received words across swept polynomials, frame sizes and message lengths. They also cover accumulator carry-over, freeze and clear across messages, detection of a deliberately corrupted CRC, and the absence of the extra frame when CRC is disabled.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_DATA, SEQ_CRC} seq_t;
  typedef enum logic {SH_IDLE, SH_RUN} shf_t;
endpackage

// File: rtl/spi_crc_rst_sync.sv
module spi_crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/spi_crc_accum.sv
module spi_crc_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  input  logic         wide,
  input  logic [W-1:0] poly,
  output logic [W-1:0] acc
);
  localparam int HW = W / 2;

  logic [W-1:0] acc_q, acc_d, mask, shl;
  logic         top, fb;

  always_comb begin
    mask  = wide ? {W{1'b1}} : {{(W-HW){1'b0}}, {HW{1'b1}}};
    top   = wide ? acc_q[W-1] : acc_q[HW-1];
    fb    = bit_in ^ top;
    shl   = {acc_q[W-2:0], 1'b0} ^ (fb ? poly : {W{1'b0}});
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = shl & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/spi_crc_shifter.sv
module spi_crc_shifter
  import spi_crc_pkg::*;
#(
  parameter int W    = 16,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         wide,
  input  logic [W-1:0] load,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         bit_stb,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int HW  = W / 2;
  localparam int CW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW = $clog2(W);
  localparam logic [CW-1:0]  DIV_END = CW'(HALF - 1);
  localparam logic [BCW-1:0] LAST_W  = BCW'(W - 1);
  localparam logic [BCW-1:0] LAST_H  = BCW'(HW - 1);

  shf_t           st_q, st_d;
  logic [CW-1:0]  div_q, div_d;
  logic [BCW-1:0] cnt_q, cnt_d;
  logic [W-1:0]   tsr_q, tsr_d, rsr_q, rsr_d;
  logic           sck_q, sck_d, done_q, done_d, tick;
  logic [BCW-1:0] last_idx;

  assign tick     = (div_q == DIV_END);
  assign last_idx = wide ? LAST_W : LAST_H;

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    tsr_d  = tsr_q;
    rsr_d  = rsr_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_d  = SH_RUN;
          tsr_d = load;
          rsr_d = '0;
          cnt_d = '0;
          div_d = '0;
          sck_d = 1'b0;
        end
      end
      default: begin
        div_d = tick ? '0 : div_q + CW'(1);
        if (tick) begin
          sck_d = ~sck_q;
          if (!sck_q) begin
            rsr_d = {rsr_q[W-2:0], miso};
          end else if (cnt_q == last_idx) begin
            st_d   = SH_IDLE;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + BCW'(1);
            tsr_d = {tsr_q[W-2:0], 1'b0};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      div_q  <= '0;
      cnt_q  <= '0;
      tsr_q  <= '0;
      rsr_q  <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      tsr_q  <= tsr_d;
      rsr_q  <= rsr_d;
      sck_q  <= sck_d;
      done_q <= done_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = wide ? tsr_q[W-1] : tsr_q[HW-1];
  assign bit_stb = (st_q == SH_RUN) && tick && !sck_q;
  assign done    = done_q;
  assign rx_word = rsr_q;
endmodule

// File: rtl/spi_crc_master.sv
module spi_crc_master
  import spi_crc_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poly_we,
  input  logic [FRAME_W-1:0] poly_wdata,
  input  logic               ctrl_we,
  input  logic               ctrl_crc_en,
  input  logic               ctrl_frame16,
  input  logic               ctrl_err_ie,
  input  logic               err_clr_we,
  input  logic               err_clr,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               tx_last,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_data,
  output logic               crc_pend,
  output logic               crc_err,
  output logic               irq,
  output logic               sck,
  output logic               mosi,
  input  logic               miso
);
  localparam int HW = FRAME_W / 2;

  logic               rst_sn;
  seq_t               st_q, st_d;
  logic [FRAME_W-1:0] poly_q, poly_d, rxd_q, rxd_d;
  logic               crc_en_q, crc_en_d, wide_q, wide_d, ie_q, ie_d;
  logic               err_q, err_d, pend_q, pend_d, rxv_q, rxv_d;
  logic               accept, go_crc, sh_start, sh_bit, sh_done;
  logic [FRAME_W-1:0] sh_load, sh_rx, tx_masked;
  logic               crc_clr, crc_upd;
  logic [1:0]         acc_bit;
  logic [FRAME_W-1:0] acc_val [2];

  spi_crc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  assign accept    = (st_q == SEQ_IDLE) && tx_valid;
  assign go_crc    = (st_q == SEQ_DATA) && sh_done && pend_q;
  assign sh_start  = accept || go_crc;
  assign tx_masked = wide_q ? tx_data : {{(FRAME_W-HW){1'b0}}, tx_data[HW-1:0]};
  assign sh_load   = go_crc ? acc_val[0] : tx_masked;
  assign crc_upd   = sh_bit && crc_en_q && (st_q == SEQ_DATA);
  assign crc_clr   = ctrl_we && ctrl_crc_en && !crc_en_q;

  spi_crc_shifter #(.W(FRAME_W), .HALF(HALF_DIV)) u_shf (
    .clk(clk), .rst_n(rst_sn), .start(sh_start), .wide(wide_q),
    .load(sh_load), .miso(miso), .sck(sck), .mosi(mosi),
    .bit_stb(sh_bit), .done(sh_done), .rx_word(sh_rx)
  );

  assign acc_bit[0] = mosi;
  assign acc_bit[1] = miso;

  for (genvar g = 0; g < 2; g++) begin : g_acc
    spi_crc_accum #(.W(FRAME_W)) u_acc (
      .clk(clk), .rst_n(rst_sn), .clr(crc_clr), .en(crc_upd),
      .bit_in(acc_bit[g]), .wide(wide_q), .poly(poly_q), .acc(acc_val[g])
    );
  end

  always_comb begin
    st_d     = st_q;
    poly_d   = poly_q;
    crc_en_d = crc_en_q;
    wide_d   = wide_q;
    ie_d     = ie_q;
    err_d    = err_q;
    pend_d   = pend_q;
    rxv_d    = 1'b0;
    rxd_d    = rxd_q;

    if (poly_we) poly_d = poly_wdata;
    if (ctrl_we) begin
      crc_en_d = ctrl_crc_en;
      ie_d     = ctrl_err_ie;
      if ((st_q == SEQ_IDLE) && !accept) wide_d = ctrl_frame16;
    end
    if (err_clr_we && err_clr) err_d = 1'b0;

    case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          st_d   = SEQ_DATA;
          pend_d = tx_last && crc_en_q;
        end
      end
      SEQ_DATA: begin
        if (sh_done) begin
          rxv_d = 1'b1;
          rxd_d = sh_rx;
          st_d  = pend_q ? SEQ_CRC : SEQ_IDLE;
        end
      end
      default: begin
        if (sh_done) begin
          st_d   = SEQ_IDLE;
          pend_d = 1'b0;
          if (sh_rx != acc_val[1]) err_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q     <= SEQ_IDLE;
      poly_q   <= '0;
      crc_en_q <= 1'b0;
      wide_q   <= 1'b0;
      ie_q     <= 1'b0;
      err_q    <= 1'b0;
      pend_q   <= 1'b0;
      rxv_q    <= 1'b0;
      rxd_q    <= '0;
    end else begin
      st_q     <= st_d;
      poly_q   <= poly_d;
      crc_en_q <= crc_en_d;
      wide_q   <= wide_d;
      ie_q     <= ie_d;
      err_q    <= err_d;
      pend_q   <= pend_d;
      rxv_q    <= rxv_d;
      rxd_q    <= rxd_d;
    end
  end

  assign tx_ready = (st_q == SEQ_IDLE);
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign crc_pend = pend_q;
  assign crc_err  = err_q;
  assign irq      = err_q && ie_q;
endmodule

// File: rtl/spi_crc_master_chk.sv
module spi_crc_master_chk #(
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_last,
  input logic tx_ready,
  input logic rx_valid,
  input logic crc_pend,
  input logic crc_err,
  input logic irq,
  input logic err_clr_we,
  input logic err_clr,
  input logic sck,
  input logic mosi,
  input logic crc_en,
  input logic wide
);
  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !sck);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && crc_en) |=> crc_pend);

  p_crc_not_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_pend) |-> !rx_valid);

  p_irq_needs_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> crc_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !(err_clr_we && err_clr)) |=> crc_err);

  p_size_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |=> $stable(wide));
endmodule

bind spi_crc_master spi_crc_master_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_last(tx_last),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .crc_pend(crc_pend),
  .crc_err(crc_err), .irq(irq), .err_clr_we(err_clr_we), .err_clr(err_clr),
  .sck(sck), .mosi(mosi), .crc_en(crc_en_q), .wide(wide_q)
);

// File: tb/tb_spi_crc_master.sv
`timescale 1ns/1ps
module tb_spi_crc_master;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic poly_we, ctrl_we, ctrl_crc_en, ctrl_frame16, ctrl_err_ie;
  logic err_clr_we, err_clr, tx_valid, tx_last;
  logic [FW-1:0] poly_wdata, tx_data;
  logic tx_ready, rx_valid, crc_pend, crc_err, irq, sck, mosi, miso;
  logic [FW-1:0] rx_data;

  always #2.5 clk = ~clk;

  spi_crc_master #(.FRAME_W(FW), .HALF_DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .poly_we(poly_we), .poly_wdata(poly_wdata),
    .ctrl_we(ctrl_we), .ctrl_crc_en(ctrl_crc_en), .ctrl_frame16(ctrl_frame16),
    .ctrl_err_ie(ctrl_err_ie), .err_clr_we(err_clr_we), .err_clr(err_clr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .crc_pend(crc_pend), .crc_err(crc_err), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  bit exp_mosi [0:511];
  bit got_mosi [0:511];
  bit miso_bits [0:511];
  int exp_n, got_n, miso_idx, rx_n;
  int rx_got [0:15];
  logic sck_prev = 1'b0;
  bit pend_seen;

  int m_tx, m_rx;
  bit m_en, m_wide, m_ie, m_err, m_poly_set;
  int m_poly;

  assign miso = miso_bits[miso_idx];

  always @(negedge clk) begin
    if (sck && !sck_prev && got_n < 512) begin
      got_mosi[got_n] = mosi;
      got_n++;
    end
    if (!sck && sck_prev && miso_idx < 511) miso_idx++;
    if (rx_valid && rx_n < 16) begin
      rx_got[rx_n] = int'(rx_data);
      rx_n++;
    end
    if (crc_pend) pend_seen = 1'b1;
    sck_prev = sck;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int crc_step(int acc, int word, int nb, int poly);
    int msk = (1 << nb) - 1;
    int a = acc;
    for (int i = nb - 1; i >= 0; i--) begin
      int b = (word >> i) & 1;
      int t = (a >> (nb - 1)) & 1;
      a = (a << 1) & msk;
      if ((b ^ t) != 0) a = (a ^ poly) & msk;
    end
    return a;
  endfunction

  task automatic set_poly(int p);
    @(negedge clk);
    poly_we = 1'b1; poly_wdata = FW'(p);
    @(negedge clk);
    poly_we = 1'b0;
    m_poly = p;
  endtask

  task automatic set_ctrl(bit en, bit wide, bit ie);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_crc_en = en; ctrl_frame16 = wide; ctrl_err_ie = ie;
    @(negedge clk);
    ctrl_we = 1'b0;
    if (en && !m_en) begin m_tx = 0; m_rx = 0; end
    m_en = en; m_wide = wide; m_ie = ie;
  endtask

  task automatic err_write(bit v);
    @(negedge clk);
    err_clr_we = 1'b1; err_clr = v;
    @(negedge clk);
    err_clr_we = 1'b0; err_clr = 1'b0;
    if (v) m_err = 1'b0;
  endtask

  task automatic run_msg(int n, bit with_last, bit corrupt, bit poke);
    int nb = m_wide ? 16 : 8;
    int msk = (1 << nb) - 1;
    int tw [0:7];
    int sw [0:7];
    int exp_crc, got_crc, bad, crc_on;
    exp_n = 0; got_n = 0; miso_idx = 0; rx_n = 0; pend_seen = 1'b0;
    for (int f = 0; f < n; f++) begin
      tw[f] = int'($urandom) & msk;
      sw[f] = int'($urandom) & msk;
      for (int i = nb - 1; i >= 0; i--) begin
        exp_mosi[exp_n] = bit'((tw[f] >> i) & 1);
        miso_bits[exp_n] = bit'((sw[f] >> i) & 1);
        exp_n++;
      end
      m_tx = crc_step(m_tx, tw[f], nb, m_poly & msk);
      m_rx = crc_step(m_rx, sw[f], nb, m_poly & msk);
    end
    crc_on = (with_last && m_en) ? 1 : 0;
    exp_crc = m_tx;
    if (crc_on != 0) begin
      int scrc = corrupt ? (m_rx ^ 1) : m_rx;
      for (int i = nb - 1; i >= 0; i--) begin
        exp_mosi[exp_n] = bit'((m_tx >> i) & 1);
        miso_bits[exp_n] = bit'((scrc >> i) & 1);
        exp_n++;
      end
      if (corrupt) m_err = 1'b1;
    end
    for (int f = 0; f < n; f++) begin
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data = FW'(tw[f]) | (m_wide ? 16'h0000 : 16'hA500);
      tx_last = with_last && (f == n - 1);
      @(negedge clk);
      tx_valid = 1'b0; tx_last = 1'b0;
      if (poke && f == 0) begin
        ctrl_we = 1'b1; ctrl_crc_en = m_en; ctrl_frame16 = !m_wide; ctrl_err_ie = m_ie;
        @(negedge clk);
        ctrl_we = 1'b0;
      end
    end
    @(negedge clk);
    while (!tx_ready || crc_pend) @(negedge clk);
    repeat (3) @(negedge clk);

    chk(got_n == exp_n, "R5", "bits on mosi (extra frame only when flagged and enabled)", got_n, exp_n);
    bad = 0;
    for (int i = 0; i < n * nb; i++) if (got_mosi[i] != exp_mosi[i]) bad++;
    chk(bad == 0, "R2", "mismatching data bits on mosi", bad, 0);
    if (crc_on != 0) begin
      got_crc = 0;
      for (int i = 0; i < nb; i++) got_crc = (got_crc << 1) | int'(got_mosi[n * nb + i]);
      chk(got_crc == exp_crc, "R4", "transmitted CRC frame", got_crc, exp_crc);
    end else begin
      chk(pend_seen == 1'b0, "R5", "crc_pend raised with CRC disabled", int'(pend_seen), 0);
    end
    chk(rx_n == n, "R8", "rx_valid pulses (CRC frame excluded)", rx_n, n);
    bad = 0;
    for (int f = 0; f < n && f < rx_n; f++) if (rx_got[f] != sw[f]) bad++;
    chk(bad == 0, "R3", "received data words wrong", bad, 0);
    chk(crc_pend == 1'b0, "R5", "crc_pend after CRC frame", int'(crc_pend), 0);
    chk(crc_err == m_err, "R8", "crc_err after message", int'(crc_err), int'(m_err));
    chk(irq == (m_err && m_ie), "R9", "irq after message", int'(irq), int'(m_err && m_ie));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p8 [0:2];
    int p16 [0:2];
    p8[0] = 'h07; p8[1] = 'h31; p8[2] = 'h9B;
    p16[0] = 'h1021; p16[1] = 'h8005; p16[2] = 'h3D65;
    rst_n = 1'b0;
    poly_we = 0; ctrl_we = 0; ctrl_crc_en = 0; ctrl_frame16 = 0; ctrl_err_ie = 0;
    err_clr_we = 0; err_clr = 0; tx_valid = 0; tx_last = 0;
    poly_wdata = '0; tx_data = '0;
    m_tx = 0; m_rx = 0; m_en = 0; m_wide = 0; m_ie = 0; m_err = 0; m_poly = 0;
    m_poly_set = 0;
    exp_n = 0; got_n = 0; miso_idx = 0; rx_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(sck == 1'b0, "R1", "sck after reset", int'(sck), 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
    chk(crc_pend == 1'b0, "R1", "crc_pend after reset", int'(crc_pend), 0);
    chk(crc_err == 1'b0, "R1", "crc_err after reset", int'(crc_err), 0);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);

    // Sweep of frame sizes, polynomials and lengths; accumulators carry over (R4, R6)
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < 3; p++) begin
        set_poly(w == 1 ? p16[p] : p8[p]);
        set_ctrl(1'b0, bit'(w), 1'b1);
        set_ctrl(1'b1, bit'(w), 1'b1);
        for (int len = 1; len <= 4; len++) run_msg(len, 1'b1, 1'b0, 1'b0);
      end
    end

    // Corrupted CRC, interrupt gating, write-one-to-clear (R8, R9, R10)
    run_msg(2, 1'b1, 1'b1, 1'b0);
    set_ctrl(1'b1, 1'b1, 1'b0);
    chk(irq == 1'b0, "R9", "irq with interrupt disabled", int'(irq), 0);
    set_ctrl(1'b1, 1'b1, 1'b1);
    chk(irq == 1'b1, "R9", "irq re-enabled with flag set", int'(irq), 1);
    err_write(1'b0);
    chk(crc_err == 1'b1, "R10", "crc_err after writing 0", int'(crc_err), 1);
    err_write(1'b1);
    chk(crc_err == 1'b0, "R10", "crc_err after writing 1", int'(crc_err), 0);
    chk(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);

    // Accumulate without CRC, then clear by re-enable (R7)
    run_msg(3, 1'b0, 1'b0, 1'b0);
    set_ctrl(1'b0, 1'b1, 1'b1);
    set_ctrl(1'b1, 1'b1, 1'b1);
    chk(m_tx == 0 && m_rx == 0, "R7", "model cleared on enable", m_tx, 0);
    run_msg(1, 1'b1, 1'b0, 1'b0);

    // tx_last with CRC disabled has no effect (R5)
    set_ctrl(1'b0, 1'b1, 1'b1);
    run_msg(2, 1'b1, 1'b0, 1'b0);

    // Frame size write while busy is ignored (R11)
    set_ctrl(1'b0, 1'b0, 1'b1);
    set_ctrl(1'b1, 1'b0, 1'b1);
    set_poly('h07);
    run_msg(3, 1'b1, 1'b0, 1'b1);
    run_msg(1, 1'b1, 1'b0, 1'b0);
    chk(got_n == 16, "R11", "bits in 8-bit message after ignored size write", got_n, 16);

    // 8-bit corrupted CRC (R8)
    run_msg(1, 1'b1, 1'b1, 1'b0);
    err_write(1'b1);
    chk(crc_err == 1'b0, "R10", "crc_err cleared in 8-bit mode", int'(crc_err), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule